// File: doc/BRIEF.md
# Serial DAC Input Frame Receiver

This block is the digital front end of a single-channel 18-bit digital-to-analog converter. It receives a three-wire serial stream made of an active-low frame select, a serial clock and a data line. It samples all three in a faster system clock domain, assembles 24-bit frames, and loads the 18-bit code field into the DAC code register when a frame completes. A frame that the select line cuts short is discarded and leaves the code untouched. The power-on value of the code register is either zero scale or midscale, chosen by a build parameter.

A controller lowers `sync_n_in` and then sends 24 bits, most significant first. Each bit is taken on a falling edge of `sclk_in`. The receiver is built around a three-state machine. In IDLE it waits for a high-to-low transition of the select line, which takes it to SHIFT. In SHIFT, a select rise moves it back to IDLE and discards the partial frame. If no rise comes first, the 24th falling clock edge commits the frame and moves it to HOLD. HOLD ignores all clock edges until the select line rises, which returns it to IDLE. The code register drives `dac_code` and raises `dac_update` for one system clock cycle when it loads.

Top module: `dac_frame_rx`

## Requirements
- R1: After reset, `dac_code` holds 0x20000 when `MIDSCALE_RESET` is 1 (the default) and 0x00000 when it is 0. `dac_update` and `reserved_err` are 0.
- R2: A frame begins only on a high-to-low transition of `sync_n_in`. After a frame has committed, clock edges have no effect while `sync_n_in` stays low. The line must go high and fall again before the next frame is accepted.
- R3: While a frame is open, `din_in` is taken on each falling edge of `sclk_in`. The first bit taken is frame bit 23 and the last is frame bit 0.
- R4: On the 24th falling edge, frame bits 19..2 are loaded into `dac_code`, with bit 19 as the code MSB. Frame bits 23, 22, 1 and 0 do not affect `dac_code`.
- R5: `dac_update` is high for exactly one system clock cycle for each committed frame, in the cycle in which `dac_code` takes its new value. `dac_code` never changes in any other cycle.
- R6: If `sync_n_in` rises before the 24th falling edge, the frame is dropped. `dac_code` and `reserved_err` keep their values, no update pulse is issued, and the next frame is decoded from its own bits only.
- R7: Falling clock edges after the 24th, while `sync_n_in` stays low, produce no further update and no change of `dac_code`.
- R8: If a committed frame has a nonzero reserved field (frame bits 21..20), its code still loads and `reserved_err` goes to 1. The flag stays at 1 until reset. A dropped frame never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4 times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_n_in | input | 1 | Active-low frame select, asynchronous to clk |
| sclk_in | input | 1 | Serial clock, asynchronous to clk; data is taken on its falling edge |
| din_in | input | 1 | Serial data, MSB first |
| dac_code | output | 18 | DAC code register |
| dac_update | output | 1 | One-cycle pulse when dac_code loads |
| reserved_err | output | 1 | Sticky flag: a committed frame had nonzero reserved bits |

## Verification
The main decode path is driven with several kinds of frame: all-ones and all-zeros data, a mixed pattern with the don't-care head bits set, and a pattern with the trailing bits set. Together these show whether the code is cut from the right bit positions and whether the ignored bits leak into it. Frames cut off after 23 and after 10 edges test the abort path: the second of these carries nonzero reserved bits, so it also shows whether the error flag wrongly counts dropped frames. A frame with 30 edges tells a single commit apart from repeated loads. A frame sent with the select line held low after a committed frame tells an edge-triggered frame start apart from a level-triggered one. A frame with reserved bits set shows that the code loads and the flag sticks.

// File: rtl/dacrx_pkg.sv
package dacrx_pkg;

    // Frame receiver states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for frame select to fall
        ST_SHIFT = 2'd1,   // collecting bits on serial clock falls
        ST_HOLD  = 2'd2    // frame committed, waiting for select to rise
    } rx_state_e;

endpackage

// File: rtl/dacrx_sync.sv
module dacrx_sync #(
    parameter int          WIDTH     = 3,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= {STAGES{RESET_VAL[b]}};
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], async_in[b]};
                end
            end
            assign sync_out[b] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/dacrx_edge.sv
module dacrx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_lvl,
    input  logic sclk_lvl,
    output logic sync_fall,
    output logic sync_rise,
    output logic sclk_fall
);

    logic sync_prev_q;
    logic sclk_prev_q;

    // Idle levels of both lines are high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_prev_q <= 1'b1;
            sclk_prev_q <= 1'b1;
        end else begin
            sync_prev_q <= sync_lvl;
            sclk_prev_q <= sclk_lvl;
        end
    end

    assign sync_fall = sync_prev_q & ~sync_lvl;
    assign sync_rise = ~sync_prev_q & sync_lvl;
    assign sclk_fall = sclk_prev_q & ~sclk_lvl;

endmodule

// File: rtl/dacrx_frame_fsm.sv
module dacrx_frame_fsm
    import dacrx_pkg::*;
#(
    parameter int FRAME_W = 24,
    parameter int TRAIL_W = 2,
    parameter int KEEP_W  = 20,
    localparam int CNT_W  = $clog2(FRAME_W),
    localparam int CAP_N  = FRAME_W - TRAIL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_fall,
    input  logic              sync_rise,
    input  logic              sclk_fall,
    input  logic              din,
    output logic              commit_q,
    output logic [KEEP_W-1:0] word_q
);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [KEEP_W-1:0] shift_q, shift_d;
    logic              commit_d;

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        shift_d  = shift_q;
        commit_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sync_fall) begin
                    state_d = ST_SHIFT;
                    cnt_d   = '0;
                    shift_d = '0;
                end
            end
            ST_SHIFT: begin
                if (sync_rise) begin
                    // early rise aborts the frame
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                    shift_d = '0;
                end else if (sclk_fall) begin
                    // trailing bits are never stored
                    if (cnt_q < CNT_W'(CAP_N)) begin
                        shift_d = {shift_q[KEEP_W-2:0], din};
                    end
                    if (cnt_q == CNT_W'(FRAME_W - 1)) begin
                        commit_d = 1'b1;
                        state_d  = ST_HOLD;
                        cnt_d    = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (sync_rise) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            shift_q <= shift_d;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit_q <= 1'b0;
            word_q   <= '0;
        end else begin
            commit_q <= commit_d;
            if (commit_d) begin
                word_q <= shift_d;
            end
        end
    end

    // R5: a commit never lasts two cycles
    p_commit_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |=> !commit_q);

    // R6: a select rise during shifting never yields a commit
    p_abort_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && sync_rise) |=> !commit_q);

    // R7: once committed, further edges are ignored
    p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && sclk_fall) |=> !commit_q);

    // R2: a frame opens only from a select fall
    p_open_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !sync_fall) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/dacrx_code_reg.sv
module dacrx_code_reg #(
    parameter int DATA_W         = 18,
    parameter int RES_W          = 2,
    parameter bit MIDSCALE_RESET = 1'b1,
    localparam int KEEP_W        = DATA_W + RES_W,
    localparam logic [DATA_W-1:0] RESET_CODE =
        MIDSCALE_RESET ? {1'b1, {(DATA_W-1){1'b0}}} : '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [KEEP_W-1:0] word,
    output logic [DATA_W-1:0] code_q,
    output logic              upd_q,
    output logic              err_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= RESET_CODE;
            upd_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            upd_q <= commit;
            if (commit) begin
                code_q <= word[DATA_W-1:0];
                if (|word[KEEP_W-1 -: RES_W]) begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    // R5: the code moves only together with the strobe
    p_code_with_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_q) |-> upd_q);

    // R8: the reserved-bit flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
    parameter int DATA_W         = 18,
    parameter int HEAD_W         = 2,
    parameter int RES_W          = 2,
    parameter int TRAIL_W        = 2,
    parameter int SYNC_STAGES    = 2,
    parameter bit MIDSCALE_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_n_in,
    input  logic              sclk_in,
    input  logic              din_in,
    output logic [DATA_W-1:0] dac_code,
    output logic              dac_update,
    output logic              reserved_err
);

    localparam int FRAME_W = HEAD_W + RES_W + DATA_W + TRAIL_W;
    localparam int KEEP_W  = RES_W + DATA_W;

    logic [2:0]        raw_in;
    logic [2:0]        lvl;
    logic              sync_fall;
    logic              sync_rise;
    logic              sclk_fall;
    logic              commit;
    logic [KEEP_W-1:0] word;

    // bit 0: select, bit 1: serial clock, bit 2: data
    assign raw_in = {din_in, sclk_in, sync_n_in};

    dacrx_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b011)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (lvl)
    );

    dacrx_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_lvl  (lvl[0]),
        .sclk_lvl  (lvl[1]),
        .sync_fall (sync_fall),
        .sync_rise (sync_rise),
        .sclk_fall (sclk_fall)
    );

    dacrx_frame_fsm #(
        .FRAME_W (FRAME_W),
        .TRAIL_W (TRAIL_W),
        .KEEP_W  (KEEP_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_fall (sync_fall),
        .sync_rise (sync_rise),
        .sclk_fall (sclk_fall),
        .din       (lvl[2]),
        .commit_q  (commit),
        .word_q    (word)
    );

    dacrx_code_reg #(
        .DATA_W         (DATA_W),
        .RES_W          (RES_W),
        .MIDSCALE_RESET (MIDSCALE_RESET)
    ) u_code (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .word   (word),
        .code_q (dac_code),
        .upd_q  (dac_update),
        .err_q  (reserved_err)
    );

endmodule

// File: tb/dac_frame_rx_bench.sv
`timescale 1ns/1ps
module dac_frame_rx_bench;

    typedef struct packed {
        logic [23:0] frame;
        logic [7:0]  edges;
    } vec_t;

    // frame word, number of falling clock edges before select rises
    localparam vec_t VECS [8] = '{
        '{24'h0FFFFC, 8'd24},   // all-ones code
        '{24'h000000, 8'd24},   // all-zeros code
        '{24'hC48D15, 8'd24},   // head bits set, code 0x12345
        '{24'h0ABCDB, 8'd23},   // aborted one edge short
        '{24'h2AAAAA, 8'd10},   // aborted, reserved bits nonzero
        '{24'h0ABCD3, 8'd24},   // trailing bits set, code 0x2AF34
        '{24'h000000, 8'd30},   // extra edges after the 24th
        '{24'h1FFFFF, 8'd24}    // reserved bits 01
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_n = 1'b1;
    logic        sclk = 1'b1;
    logic        din = 1'b0;
    logic [17:0] dac_code;
    logic        dac_update;
    logic        reserved_err;

    int checks = 0;
    int fails = 0;
    int strobes = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dac_frame_rx u_dac_frame_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_n_in    (sync_n),
        .sclk_in      (sclk),
        .din_in       (din),
        .dac_code     (dac_code),
        .dac_update   (dac_update),
        .reserved_err (reserved_err)
    );

    // counts every cycle with the strobe high
    always @(posedge clk) if (dac_update) strobes <= strobes + 1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [23:0] frame, input int edges, input bit raise);
        sync_n = 1'b0;
        tick(4);
        for (int i = 0; i < edges; i++) begin
            din = (i < 24) ? frame[23 - i] : 1'b1;
            tick(4);
            sclk = 1'b0;
            tick(4);
            sclk = 1'b1;
        end
        tick(2);
        if (raise) sync_n = 1'b1;
        tick(8);
    endtask

    initial begin
        logic [17:0] exp_code;
        logic        exp_err;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        check("R1 code", 32'(dac_code), 32'h20000);
        check("R1 update", 32'(dac_update), 32'h0);
        check("R1 err", 32'(reserved_err), 32'h0);

        exp_code = 18'h20000;
        exp_err  = 1'b0;
        foreach (VECS[k]) begin
            bit full;
            strobes = 0;
            send(VECS[k].frame, int'(VECS[k].edges), 1'b1);
            full = (VECS[k].edges >= 8'd24);
            if (full) begin
                exp_code = VECS[k].frame[19:2];
                exp_err  = exp_err | (|VECS[k].frame[21:20]);
            end
            // R3 R4 R6 R7: code taken from bits 19..2, aborts ignored
            check(full ? "R4 code" : "R6 code kept", 32'(dac_code), 32'(exp_code));
            // R5 R7: one strobe cycle per committed frame only
            check(full ? "R5 strobe" : "R6 no strobe", 32'(strobes), full ? 32'd1 : 32'd0);
            // R8: sticky flag from committed frames only
            check("R8 err", 32'(reserved_err), 32'(exp_err));
        end

        // R2: frame with select held low afterwards, then another without a fall
        strobes = 0;
        send(24'h0C0004, 24, 1'b0);
        check("R2 first frame", 32'(dac_code), 32'h30001);
        strobes = 0;
        send(24'h055554, 24, 1'b1);
        check("R2 no new frame", 32'(dac_code), 32'h30001);
        check("R2 no strobe", 32'(strobes), 32'd0);
        strobes = 0;
        send(24'h055554, 24, 1'b1);
        check("R2 after refall", 32'(dac_code), 32'h15555);

        // R1 R8: reset restores midscale and clears the flag
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        check("R1 code after reset", 32'(dac_code), 32'h20000);
        check("R8 err cleared", 32'(reserved_err), 32'h0);

        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule